// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Unit

This unit holds the three registers through which a host tracks a flash controller's operations: a controller status word with error flags, an interrupt word with a master flag and per-operation completion flags, and a system configuration word that selects the interrupt output polarity and drives a ready output. A separate command engine reports each finished operation with a one-cycle pulse that carries the operation type (reset, erase, program or load) and a fail flag, and separately flags commands it could not decode.

The host reaches the registers through a simple word port with one-cycle read latency. Interrupt flags are acknowledged by writing a mask that is ANDed into the interrupt word; once the master flag is gone, the error flags drop with it. Command words written by the host are passed on to the engine only while no interrupt is pending, so a new operation cannot start before the previous result has been acknowledged. A warm-reset pulse from the engine returns the registers to their warm values.

Top module: `flash_irq_regs`

## Requirements
- R1: After the synchronous active-low reset, the status register reads 0x0000, the interrupt register 0x8080, the configuration register 0x40C0, the command register 0x0000; ready is 1 and the interrupt output is 1. Register offsets: 0 status, 1 interrupt, 2 configuration, 3 command.
- R2: A warm-reset pulse sets status to 0x0000, interrupt to 0x8010, configuration to 0x40C0, command to 0x0000 and ready to 1, overriding any other input in that cycle.
- R3: A completion pulse sets interrupt bit 15 and the type bit: reset (kind 0) bit 4, erase (kind 1) bit 5, program (kind 2) bit 6, load (kind 3) bit 7.
- R4: A completion pulse with the fail flag also sets status bit 10 plus erase bit 11, program bit 12 or load bit 13; a failed reset sets bit 10 only.
- R5: A host write to the interrupt register replaces it with its old value ANDed with the written word.
- R6: If interrupt bit 15 is clear after such a write, status bits 10 to 13 are cleared in the same update.
- R7: The interrupt output equals interrupt bit 15 XOR the inverse of configuration bit 6, following the registers without delay.
- R8: A configuration write stores the full word and sets ready to its bit 7; configuration reads return the word with bits 4..0 forced to zero.
- R9: A command write while interrupt bit 15 is set is ignored; otherwise the word is stored and a one-cycle start pulse with that code follows in the next cycle.
- R10: An undecodable-command pulse sets status bit 10 and interrupt bit 15.
- R11: Read data appears one cycle after the read request and shows the register before any write of that cycle; a host write and an event in the same cycle apply the AND first, then the event bits.
- R12: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| warm_rst | input | 1 | Warm-reset pulse from the command engine |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data, one cycle after reg_rd |
| done_valid | input | 1 | Operation completion pulse |
| done_kind | input | 2 | Operation type: 0 reset, 1 erase, 2 program, 3 load |
| done_fail | input | 1 | Completion was a failure |
| bad_cmd | input | 1 | Command could not be decoded |
| cmd_go | output | 1 | Accepted command start pulse |
| cmd_code | output | 16 | Last accepted command word |
| irq_out | output | 1 | Level interrupt output |
| ready_out | output | 1 | Ready output |

## Verification
The bench builds the block with its default two-bit offset field, so every register offset is reachable and all four operation kinds can be swept with and without failure. That small map makes it practical to sweep every combination of the master flag and the four type bits in the acknowledge mask, both polarity settings against both master-flag states, and the same-cycle collisions of acknowledge writes with completion pulses and of command writes with a pending interrupt.

// File: rtl/flash_irq_pkg.sv
// Shared constants and types for the flash interrupt/status register unit.
// Assumes 16-bit registers; bit positions are fixed by the host software.
package flash_irq_pkg;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2,
        OP_LOAD  = 2'd3
    } op_kind_t;

    localparam int NUM_KINDS     = 4;
    localparam int INT_MASTER    = 15;
    localparam int INT_DONE_LO   = 4;
    localparam int ERR_CMD_BIT   = 10;
    localparam int CFG_POL_BIT   = 6;
    localparam int CFG_RDY_BIT   = 7;

    localparam logic [REG_W-1:0] CFG_RESET     = 16'h40C0;
    localparam logic [REG_W-1:0] INT_COLD      = 16'h8080;
    localparam logic [REG_W-1:0] INT_WARM      = 16'h8010;
    localparam logic [REG_W-1:0] CFG_READ_MASK = 16'hFFE0;
    localparam logic [REG_W-1:0] ERR_MASK      = 16'h3C00;
endpackage

// File: rtl/fir_cfg_reg.sv
// Configuration register: stores the host word and drives the ready output.
// Assumes a single write strobe already decoded for this register.
module fir_cfg_reg
    import flash_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q,
    output logic             ready
);
    // Hold configuration word; reset values on cold or warm reset.
    always_ff @(posedge clk) begin
        if (!rst_n || warm) begin
            cfg_q <= CFG_RESET;
            ready <= 1'b1;
        end else if (wr_en) begin
            cfg_q <= wdata;
            ready <= wdata[CFG_RDY_BIT];
        end
    end

    // R8
    // ready_follow_chk
    ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !warm) |=> (ready == $past(wdata[CFG_RDY_BIT])) && (cfg_q == $past(wdata)));

    // R2
    // cfg_warm_chk
    cfg_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |=> (cfg_q == CFG_RESET) && ready);
endmodule

// File: rtl/fir_event_regs.sv
// Interrupt and status registers: merge host acknowledge writes with
// completion and bad-command events. The AND of a host write is applied
// first, the error auto-clear sees the AND result, event bits are ORed last.
module fir_event_regs
    import flash_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm,
    input  logic             int_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             done_valid,
    input  logic [1:0]       done_kind,
    input  logic             done_fail,
    input  logic             bad_cmd,
    output logic [REG_W-1:0] int_q,
    output logic [REG_W-1:0] stat_q
);
    logic [REG_W-1:0]     int_and;
    logic [REG_W-1:0]     stat_clr;
    logic [REG_W-1:0]     int_d;
    logic [REG_W-1:0]     stat_d;
    logic [NUM_KINDS-1:0] kind_hot;

    // Decode operation type into a one-hot flag vector.
    always_comb kind_hot = NUM_KINDS'(1) << done_kind;

    // Next-state: acknowledge AND, error auto-clear, then event set.
    always_comb begin
        int_and  = int_wr ? (int_q & wdata) : int_q;
        stat_clr = (int_wr && !int_and[INT_MASTER]) ? (stat_q & ~ERR_MASK) : stat_q;
        int_d    = int_and;
        stat_d   = stat_clr;
        if (done_valid) begin
            int_d[INT_MASTER] = 1'b1;
            int_d[INT_DONE_LO +: NUM_KINDS] = int_d[INT_DONE_LO +: NUM_KINDS] | kind_hot;
            if (done_fail) begin
                stat_d[ERR_CMD_BIT] = 1'b1;
                stat_d[ERR_CMD_BIT+1 +: NUM_KINDS-1] =
                    stat_d[ERR_CMD_BIT+1 +: NUM_KINDS-1] | kind_hot[NUM_KINDS-1:1];
            end
        end
        if (bad_cmd) begin
            int_d[INT_MASTER]   = 1'b1;
            stat_d[ERR_CMD_BIT] = 1'b1;
        end
    end

    // Register update with cold and warm reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= INT_COLD;
            stat_q <= '0;
        end else if (warm) begin
            int_q  <= INT_WARM;
            stat_q <= '0;
        end else begin
            int_q  <= int_d;
            stat_q <= stat_d;
        end
    end

    // R3
    // done_flag_chk
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !warm) |=> int_q[INT_MASTER] &&
        ((int_q[INT_DONE_LO +: NUM_KINDS] & (NUM_KINDS'(1) << $past(done_kind))) != '0));

    // R4
    // fail_err_chk
    fail_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fail && !warm) |=> stat_q[ERR_CMD_BIT]);

    // R5
    // ack_and_chk
    ack_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr && !done_valid && !bad_cmd && !warm) |=> ((int_q & ~$past(wdata)) == '0));

    // R6
    // err_autoclr_chk
    err_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr && !wdata[INT_MASTER] && !done_valid && !bad_cmd && !warm)
        |=> ((stat_q & ERR_MASK) == '0));

    // R10
    // bad_cmd_chk
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cmd && !warm) |=> int_q[INT_MASTER] && stat_q[ERR_CMD_BIT]);
endmodule

// File: rtl/fir_cmd_gate.sv
// Command gate: accepts a host command word only while no interrupt is
// pending and issues a one-cycle start pulse with the stored code.
module fir_cmd_gate
    import flash_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             int_busy,
    output logic [REG_W-1:0] cmd_q,
    output logic             cmd_go
);
    logic accept;

    // A write is taken only when the master interrupt flag is clear.
    always_comb accept = cmd_wr && !int_busy;

    // Store the accepted word and pulse the start output.
    always_ff @(posedge clk) begin
        if (!rst_n || warm) begin
            cmd_q  <= '0;
            cmd_go <= 1'b0;
        end else begin
            cmd_go <= accept;
            if (accept) cmd_q <= wdata;
        end
    end

    // R9
    // cmd_block_chk
    cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && int_busy) |=> !cmd_go);

    // R9
    // cmd_pass_chk
    cmd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !int_busy && !warm) |=> cmd_go && (cmd_q == $past(wdata)));
endmodule

// File: rtl/flash_irq_regs.sv
// Top of the flash interrupt/status register unit: decodes the host port,
// registers read data and forms the interrupt output from the registers.
// Assumes at most one host access per cycle and engine pulses one cycle long.
module flash_irq_regs
    import flash_irq_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int OFS_STAT = 0,
    parameter int OFS_INT  = 1,
    parameter int OFS_CFG  = 2,
    parameter int OFS_CMD  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              done_valid,
    input  logic [1:0]        done_kind,
    input  logic              done_fail,
    input  logic              bad_cmd,
    output logic              cmd_go,
    output logic [15:0]       cmd_code,
    output logic              irq_out,
    output logic              ready_out
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(OFS_INT);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);

    logic [REG_W-1:0] int_q, stat_q, cfg_q;
    logic             wr_int, wr_cfg, wr_cmd;
    logic [REG_W-1:0] rd_mux;

    // Host write decode per register.
    always_comb begin
        wr_int = reg_wr && (reg_addr == A_INT);
        wr_cfg = reg_wr && (reg_addr == A_CFG);
        wr_cmd = reg_wr && (reg_addr == A_CMD);
    end

    fir_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .warm  (warm_rst),
        .wr_en (wr_cfg),
        .wdata (reg_wdata),
        .cfg_q (cfg_q),
        .ready (ready_out)
    );

    fir_event_regs u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm       (warm_rst),
        .int_wr     (wr_int),
        .wdata      (reg_wdata),
        .done_valid (done_valid),
        .done_kind  (done_kind),
        .done_fail  (done_fail),
        .bad_cmd    (bad_cmd),
        .int_q      (int_q),
        .stat_q     (stat_q)
    );

    fir_cmd_gate u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm     (warm_rst),
        .cmd_wr   (wr_cmd),
        .wdata    (reg_wdata),
        .int_busy (int_q[INT_MASTER]),
        .cmd_q    (cmd_code),
        .cmd_go   (cmd_go)
    );

    // Interrupt level: master flag with polarity chosen by configuration.
    always_comb irq_out = int_q[INT_MASTER] ^ ~cfg_q[CFG_POL_BIT];

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_STAT) rd_mux = stat_q;
        if (reg_addr == A_INT)  rd_mux = int_q;
        if (reg_addr == A_CFG)  rd_mux = cfg_q & CFG_READ_MASK;
        if (reg_addr == A_CMD)  rd_mux = cmd_code;
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R11
    // rd_int_latency_chk
    rd_int_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_INT) |=> (reg_rdata == $past(int_q)));

    // R12
    // stat_wr_ignored_chk
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && !done_valid && !bad_cmd && !warm_rst)
        |=> (stat_q == $past(stat_q)));
endmodule

// File: tb/tb_flash_irq_regs.sv
module tb_flash_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        done_valid = 1'b0;
    logic [1:0]  done_kind = '0;
    logic        done_fail = 1'b0;
    logic        bad_cmd = 1'b0;
    logic        cmd_go;
    logic [15:0] cmd_code;
    logic        irq_out;
    logic        ready_out;

    int n_chk = 0;
    int n_fail = 0;

    // Bench-side expected register state
    logic [15:0] m_int, m_stat, m_cfg, m_cmd;
    logic        m_rdy, m_go;

    always #5 clk = ~clk;

    flash_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_valid(done_valid), .done_kind(done_kind), .done_fail(done_fail),
        .bad_cmd(bad_cmd), .cmd_go(cmd_go), .cmd_code(cmd_code),
        .irq_out(irq_out), .ready_out(ready_out)
    );

    task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; expected state follows the requirements.
    task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] wd,
                        input logic dv, input logic [1:0] k, input logic fl,
                        input logic bd, input logic wm);
        logic [15:0] old_int;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        done_valid = dv; done_kind = k; done_fail = fl; bad_cmd = bd; warm_rst = wm;
        old_int = m_int;
        m_go = 1'b0;
        if (wm) begin
            m_int = 16'h8010; m_stat = 16'h0000; m_cfg = 16'h40C0; m_cmd = 16'h0000; m_rdy = 1'b1;
        end else begin
            if (wr && a == 2'd1) begin
                m_int = m_int & wd;
                if (!m_int[15]) m_stat = m_stat & 16'hC3FF;
            end
            if (wr && a == 2'd2) begin m_cfg = wd; m_rdy = wd[7]; end
            if (wr && a == 2'd3 && !old_int[15]) begin m_cmd = wd; m_go = 1'b1; end
            if (dv) begin
                m_int = m_int | 16'h8000 | (16'h0010 << k);
                if (fl) m_stat = m_stat | 16'h0400 | ((k == 2'd0) ? 16'h0 : (16'h0400 << k));
            end
            if (bd) begin m_int = m_int | 16'h8000; m_stat = m_stat | 16'h0400; end
        end
        @(negedge clk);
        reg_wr = 1'b0; done_valid = 1'b0; done_fail = 1'b0; bad_cmd = 1'b0; warm_rst = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        cmp(tag, reg_rdata, exp);
    endtask

    task automatic chk_all(input string tag);
        cmp({tag, " R7 irq"}, {15'd0, irq_out}, {15'd0, m_int[15] ^ ~m_cfg[6]});
        cmp({tag, " R8 ready"}, {15'd0, ready_out}, {15'd0, m_rdy});
        rd_chk(2'd0, m_stat, {tag, " R11 status"});
        rd_chk(2'd1, m_int, {tag, " R11 intr"});
        rd_chk(2'd2, m_cfg & 16'hFFE0, {tag, " R8 cfg"});
        rd_chk(2'd3, m_cmd, {tag, " R9 cmd"});
    endtask

    task automatic ack_all();
        step(1'b1, 2'd1, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_int = 16'h8080; m_stat = 16'h0000; m_cfg = 16'h40C0; m_cmd = 16'h0000;
        m_rdy = 1'b1; m_go = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 cold reset values
        chk_all("R1 reset");

        // R3 R4 every kind, with and without failure
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 2; f++) begin
                ack_all();
                step(1'b0, 2'd0, 16'h0, 1'b1, 2'(k), 1'(f), 1'b0, 1'b0);
                chk_all(f ? "R4 fail" : "R3 done");
            end
        end

        // R5 R6 sweep of master flag and type bits in acknowledge mask
        for (int i = 0; i < 32; i++) begin
            ack_all();
            step(1'b0, 2'd0, 16'h0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
            step(1'b0, 2'd0, 16'h0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
            step(1'b0, 2'd0, 16'h0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
            step(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
            step(1'b1, 2'd1, (16'(i & 1) << 15) | (16'((i >> 1) & 15) << 4) | 16'h0F0F,
                 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
            chk_all("R5 R6 ack sweep");
        end

        // R7 polarity against master flag
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 2; m++) begin
                step(1'b1, 2'd2, p ? 16'h40C0 : 16'h0080, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
                ack_all();
                if (m) step(1'b0, 2'd0, 16'h0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
                chk_all("R7 polarity");
            end
        end

        // R8 configuration words: readback mask and ready
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 2'd2, 16'(i * 16'h1357) ^ 16'hA5A5, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
            chk_all("R8 cfg word");
        end

        // R9 command gating with master flag set, then clear
        ack_all();
        step(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 2'd3, 16'h0094, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        cmp("R9 blocked go", {15'd0, cmd_go}, {15'd0, m_go});
        chk_all("R10 R9 blocked");
        ack_all();
        step(1'b1, 2'd3, 16'h0080, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        cmp("R9 accepted go", {15'd0, cmd_go}, {15'd0, m_go});
        cmp("R9 code", cmd_code, 16'h0080);
        @(negedge clk);
        cmp("R9 go one cycle", {15'd0, cmd_go}, 16'd0);
        chk_all("R9 accepted");

        // R11 same-cycle acknowledge write and completion pulse
        step(1'b0, 2'd0, 16'h0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 2'd1, 16'h0000, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
        chk_all("R11 collision");
        // R11 read shows value before same-cycle write
        reg_rd = 1'b1;
        step(1'b1, 2'd1, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        reg_rd = 1'b0;
        cmp("R11 read before write", reg_rdata, 16'h8080);
        chk_all("R11 after ack");

        // R12 status write ignored
        step(1'b0, 2'd0, 16'h0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0);
        step(1'b1, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'd0, 16'hFFFF, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        chk_all("R12 status ro");

        // R2 warm reset overriding a same-cycle write
        step(1'b1, 2'd2, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        chk_all("R2 warm");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule